// File: doc/BRIEF.md
# Coherent Private-Cache Request Controller

This block is the core-facing half of a private-cache coherence controller that tracks the five stable states (I, S, E, O, M) of each line in a small direct-mapped array. Each line holds one tag, one state and one data word. For every event the core presents, the controller looks up the indexed line and decides one of two things. Either it serves the event locally, or it sends a coherence request toward the interconnect: read-shared, read-for-ownership, upgrade, or a state-specific writeback/eviction notice.

Whether an event hits depends on the event type and on the line state, not only on the tag. Reads are served from any valid state. Writes and atomics need an exclusive state (E or M). A write to an E line promotes it to M without any request. After a read-shared, read-for-ownership or upgrade request, the controller stalls the core until the interconnect returns a grant. The grant installs the new state, and the stalled event is then replayed against the updated line. An atomic fetch-and-add runs as a read phase followed by a write phase. Across both phases the controller raises a hold signal that tells the snoop side not to give up write permission.

The state machine has five states. IDLE accepts core events. WAIT_GRANT stalls until a grant arrives. REPLAY re-decodes the saved event. ATOM_READ captures the old word. ATOM_WRITE stores the sum and responds. The transitions are:
- IDLE→IDLE on a local hit, a drop or an eviction.
- IDLE→WAIT_GRANT on a miss request.
- IDLE→ATOM_READ on an atomic hit.
- WAIT_GRANT→REPLAY on a grant.
- REPLAY→IDLE, REPLAY→WAIT_GRANT or REPLAY→ATOM_READ, using the same decision as IDLE.
- ATOM_READ→ATOM_WRITE.
- ATOM_WRITE→IDLE.

Top module: `coh_core_ctrl`

## Requirements
- R1: Event codes are 0 load, 1 instruction fetch, 2 store, 3 atomic fetch-and-add, 4 read-only prefetch, 5 read-write prefetch, 6 replacement, 7 reserved. A load or fetch whose tag matches a line in S, E, O or M raises resp_valid with the line's word in the cycle after acceptance. On a tag mismatch or an I line, the controller issues a read-shared request instead.
- R2: A store that hits a line in E or M writes the word and raises resp_valid (resp_data 0) in the cycle after acceptance, with no request. The line becomes M, so a later read-write prefetch is dropped and a later replacement emits a modified-writeback notice.
- R3: A store or atomic that does not hit in E or M issues an upgrade (opcode 3) when the tag matches a line in S or O, and a read-for-ownership (opcode 2) otherwise.
- R4: An atomic that hits raises perm_hold for exactly two cycles, with no request and the core stalled. In the cycle after the hold ends, resp_valid returns the old word and the line holds old word plus core_wdata in state M.
- R5: A read-only prefetch that hits is dropped (no request, no response, core stays ready). A read-only prefetch that misses issues a read-shared request, and its grant produces no response.
- R6: A read-write prefetch is dropped only when the line is M. Otherwise it issues an upgrade if the tag matches a valid line, or a read-for-ownership if it does not.
- R7: A replacement of a line in S, E, O or M issues opcode 4, 5, 6 or 7 respectively and invalidates the line without stalling. A replacement of an I line issues nothing.
- R8: After a read-shared, read-for-ownership or upgrade request, core_ready stays low until grant_valid. The grant installs grant_state and grant_data, except that an upgrade keeps the existing word. The saved event is then replayed and completes one cycle after the grant cycle.
- R9: Requests appear on req_valid for one cycle, in the cycle after the accepting edge. req_op uses 0 none, 1 read-shared, 2 read-for-ownership, 3 upgrade, 4-7 evictions of S, E, O, M. req_addr is the event address. States are encoded I=0, S=1, E=2, O=3, M=4.
- R10: The reserved event code 7 is accepted and has no effect: no request, no response, and the line is unchanged.
- R11: During and right after reset, core_ready is 1, and resp_valid, req_valid and perm_hold are 0. Every line is I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | 1 | Core presents an event |
| core_event | input | 3 | Event code (R1) |
| core_addr | input | ADDR_W | Event address; low INDEX_W bits index the array |
| core_wdata | input | DATA_W | Store data or atomic addend |
| core_ready | output | 1 | Controller can accept an event this cycle |
| resp_valid | output | 1 | Response to a load, fetch, store or atomic |
| resp_data | output | DATA_W | Read word, old word for atomics, 0 for stores |
| perm_hold | output | 1 | Write permission must not be released |
| req_valid | output | 1 | Coherence request valid |
| req_op | output | 3 | Request opcode (R9) |
| req_addr | output | ADDR_W | Request address |
| grant_valid | input | 1 | Grant for the outstanding request |
| grant_state | input | 3 | State to install (R9 encoding) |
| grant_data | input | DATA_W | Word to install |

## Verification
Local hits, drops, evictions and the reserved code show their effect one cycle after the accepting edge. The bench drives each event half a cycle before an edge and samples at the following falling edge. A grant completes its replayed event one edge later, so the bench samples a second falling edge after the grant edge. An atomic hit shows perm_hold at the first and second falling edges after acceptance and resp_valid at the third; the bench steps one falling edge at a time and checks hold, response and ready at each. State changes that are otherwise invisible, such as silent promotion to M, upgrade data retention and invalidation, are observed through the next event's request opcode or read data.

// File: rtl/coh_ctrl_pkg.sv
package coh_ctrl_pkg;

    typedef enum logic [2:0] {
        LS_I = 3'd0,
        LS_S = 3'd1,
        LS_E = 3'd2,
        LS_O = 3'd3,
        LS_M = 3'd4
    } line_state_e;

    typedef enum logic [2:0] {
        EV_LOAD    = 3'd0,
        EV_IFETCH  = 3'd1,
        EV_STORE   = 3'd2,
        EV_ATOMIC  = 3'd3,
        EV_PF_RO   = 3'd4,
        EV_PF_RW   = 3'd5,
        EV_REPLACE = 3'd6,
        EV_RSVD    = 3'd7
    } core_event_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_RDSH  = 3'd1,
        OP_RDOWN = 3'd2,
        OP_UPG   = 3'd3,
        OP_EVS   = 3'd4,
        OP_EVE   = 3'd5,
        OP_EVO   = 3'd6,
        OP_EVM   = 3'd7
    } net_op_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_WAIT_GRANT,
        F_REPLAY,
        F_ATOM_READ,
        F_ATOM_WRITE
    } fsm_e;

    typedef struct packed {
        logic    rd_hit;
        logic    wr_hit;
        logic    atom_hit;
        logic    wait_grant;
        net_op_e op;
    } decision_t;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_ctrl_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 9,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    output line_state_e        rd_state,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  line_state_e        wr_state,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_keep_data
);
    localparam int LINES = 1 << INDEX_W;

    line_state_e       st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == INDEX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g]   <= LS_I;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (sel) begin
                st_q[g]  <= wr_state;
                tag_q[g] <= wr_tag;
                if (!wr_keep_data) begin
                    data_q[g] <= wr_data;
                end
            end
        end
    end

    assign rd_state = st_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/coh_event_decode.sv
module coh_event_decode
    import coh_ctrl_pkg::*;
#(
    parameter bit PF_ISSUE = 1'b1
) (
    input  core_event_e ev,
    input  logic        present,
    input  line_state_e line_st,
    output decision_t   dec
);
    logic excl;
    assign excl = present && (line_st == LS_E || line_st == LS_M);

    always_comb begin
        dec = '0;
        unique case (ev)
            EV_LOAD, EV_IFETCH: begin
                if (present) begin
                    dec.rd_hit = 1'b1;
                end else begin
                    dec.op         = OP_RDSH;
                    dec.wait_grant = 1'b1;
                end
            end
            EV_STORE, EV_ATOMIC: begin
                if (excl) begin
                    if (ev == EV_ATOMIC) dec.atom_hit = 1'b1;
                    else                 dec.wr_hit   = 1'b1;
                end else begin
                    dec.op         = present ? OP_UPG : OP_RDOWN;
                    dec.wait_grant = 1'b1;
                end
            end
            EV_PF_RO: begin
                if (!present && PF_ISSUE) begin
                    dec.op         = OP_RDSH;
                    dec.wait_grant = 1'b1;
                end
            end
            EV_PF_RW: begin
                if (!(present && line_st == LS_M) && PF_ISSUE) begin
                    dec.op         = present ? OP_UPG : OP_RDOWN;
                    dec.wait_grant = 1'b1;
                end
            end
            EV_REPLACE: begin
                unique case (line_st)
                    LS_S:    dec.op = OP_EVS;
                    LS_E:    dec.op = OP_EVE;
                    LS_O:    dec.op = OP_EVO;
                    LS_M:    dec.op = OP_EVM;
                    default: dec.op = OP_NONE;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_pending_reg.sv
module coh_pending_reg
    import coh_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  core_event_e       ev_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  net_op_e           op_in,
    output core_event_e       ev_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output net_op_e           op_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q    <= EV_RSVD;
            addr_q  <= '0;
            wdata_q <= '0;
            op_q    <= OP_NONE;
        end else if (load_en) begin
            ev_q    <= ev_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            op_q    <= op_in;
        end
    end
endmodule

// File: rtl/coh_core_ctrl.sv
module coh_core_ctrl
    import coh_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int INDEX_W  = 3,
    parameter int DATA_W   = 16,
    parameter bit PF_ISSUE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [2:0]        core_event,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              perm_hold,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              grant_valid,
    input  logic [2:0]        grant_state,
    input  logic [DATA_W-1:0] grant_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    fsm_e fsm_q, fsm_d;

    core_event_e       pend_ev;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_wdata;
    net_op_e           pend_op;

    core_event_e       cur_ev;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [INDEX_W-1:0] cur_idx;
    logic [TAG_W-1:0]  cur_tag;

    line_state_e       rd_state;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              present;
    decision_t         dec;
    logic              act_now;
    logic              is_evict;

    logic              wr_en;
    line_state_e       wr_state;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              wr_keep;
    logic [DATA_W-1:0] atom_old_q;

    // ---------------- request source selection ----------------
    always_comb begin
        if (fsm_q == F_IDLE) begin
            cur_ev    = core_event_e'(core_event);
            cur_addr  = core_addr;
            cur_wdata = core_wdata;
        end else begin
            cur_ev    = pend_ev;
            cur_addr  = pend_addr;
            cur_wdata = pend_wdata;
        end
    end

    assign cur_idx  = cur_addr[INDEX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:INDEX_W];
    assign present  = (rd_state != LS_I) && (rd_tag == cur_tag);
    assign act_now  = (fsm_q == F_IDLE && core_valid) || (fsm_q == F_REPLAY);
    assign is_evict = (dec.op >= OP_EVS);

    coh_line_array #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_idx       (cur_idx),
        .rd_state     (rd_state),
        .rd_tag       (rd_tag),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_idx       (cur_idx),
        .wr_state     (wr_state),
        .wr_tag       (wr_tag),
        .wr_data      (wr_data),
        .wr_keep_data (wr_keep)
    );

    coh_event_decode #(
        .PF_ISSUE (PF_ISSUE)
    ) u_decode (
        .ev      (cur_ev),
        .present (present),
        .line_st (rd_state),
        .dec     (dec)
    );

    coh_pending_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (act_now),
        .ev_in    (cur_ev),
        .addr_in  (cur_addr),
        .wdata_in (cur_wdata),
        .op_in    (dec.op),
        .ev_q     (pend_ev),
        .addr_q   (pend_addr),
        .wdata_q  (pend_wdata),
        .op_q     (pend_op)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            F_IDLE, F_REPLAY: begin
                if (act_now) begin
                    if (dec.atom_hit)        fsm_d = F_ATOM_READ;
                    else if (dec.wait_grant) fsm_d = F_WAIT_GRANT;
                    else                     fsm_d = F_IDLE;
                end
            end
            F_WAIT_GRANT: if (grant_valid) fsm_d = F_REPLAY;
            F_ATOM_READ:  fsm_d = F_ATOM_WRITE;
            F_ATOM_WRITE: fsm_d = F_IDLE;
            default:      fsm_d = F_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= F_IDLE;
        else        fsm_q <= fsm_d;
    end

    // ---------------- line update ----------------
    always_comb begin
        wr_en    = 1'b0;
        wr_state = LS_M;
        wr_tag   = cur_tag;
        wr_data  = cur_wdata;
        wr_keep  = 1'b0;
        unique case (fsm_q)
            F_IDLE, F_REPLAY: begin
                if (act_now && dec.wr_hit) begin
                    wr_en = 1'b1;
                end else if (act_now && is_evict) begin
                    wr_en    = 1'b1;
                    wr_state = LS_I;
                    wr_tag   = rd_tag;
                    wr_keep  = 1'b1;
                end
            end
            F_WAIT_GRANT: begin
                if (grant_valid) begin
                    wr_en    = 1'b1;
                    wr_state = line_state_e'(grant_state);
                    wr_data  = grant_data;
                    wr_keep  = (pend_op == OP_UPG);
                end
            end
            F_ATOM_WRITE: begin
                wr_en   = 1'b1;
                wr_data = atom_old_q + pend_wdata;
            end
            default: ;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
            req_valid  <= 1'b0;
            req_op     <= OP_NONE;
            req_addr   <= '0;
            atom_old_q <= '0;
        end else begin
            resp_valid <= 1'b0;
            req_valid  <= 1'b0;
            if (act_now) begin
                if (dec.rd_hit) begin
                    resp_valid <= 1'b1;
                    resp_data  <= rd_data;
                end else if (dec.wr_hit) begin
                    resp_valid <= 1'b1;
                    resp_data  <= '0;
                end
                if (dec.op != OP_NONE) begin
                    req_valid <= 1'b1;
                    req_op    <= dec.op;
                    req_addr  <= cur_addr;
                end
            end
            if (fsm_q == F_ATOM_READ) begin
                atom_old_q <= rd_data;
            end
            if (fsm_q == F_ATOM_WRITE) begin
                resp_valid <= 1'b1;
                resp_data  <= atom_old_q;
            end
        end
    end

    assign core_ready = (fsm_q == F_IDLE);
    assign perm_hold  = (fsm_q == F_ATOM_READ) || (fsm_q == F_ATOM_WRITE);

    // ---------------- assertions ----------------
    p_req_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op != 3'd0));

    p_miss_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op >= 3'd1 && req_op <= 3'd3) |-> !core_ready);

    p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == F_WAIT_GRANT && !grant_valid) |=> !core_ready);

    p_hold_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perm_hold) |=> perm_hold);

    p_hold_release_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perm_hold) |-> resp_valid);

    p_hold_no_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        perm_hold |-> !req_valid);

endmodule

// File: tb/coh_core_ctrl_bench.sv
`timescale 1ns/1ps
module coh_core_ctrl_bench;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          core_valid;
    logic [2:0]    core_event;
    logic [AW-1:0] core_addr;
    logic [DW-1:0] core_wdata;
    logic          core_ready;
    logic          resp_valid;
    logic [DW-1:0] resp_data;
    logic          perm_hold;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [AW-1:0] req_addr;
    logic          grant_valid;
    logic [2:0]    grant_state;
    logic [DW-1:0] grant_data;

    int total = 0;
    int bad   = 0;

    // event codes, opcodes and states as given in the requirements
    localparam logic [2:0] E_LD = 3'd0, E_IF = 3'd1, E_ST = 3'd2, E_AT = 3'd3,
                           E_PR = 3'd4, E_PW = 3'd5, E_RP = 3'd6, E_RS = 3'd7;
    localparam logic [2:0] S_I = 3'd0, S_S = 3'd1, S_E = 3'd2, S_O = 3'd3, S_M = 3'd4;

    always #2.5 clk = ~clk;

    coh_core_ctrl u_coh_core_ctrl (
        .clk (clk), .rst_n (rst_n),
        .core_valid (core_valid), .core_event (core_event),
        .core_addr (core_addr), .core_wdata (core_wdata),
        .core_ready (core_ready), .resp_valid (resp_valid),
        .resp_data (resp_data), .perm_hold (perm_hold),
        .req_valid (req_valid), .req_op (req_op), .req_addr (req_addr),
        .grant_valid (grant_valid), .grant_state (grant_state),
        .grant_data (grant_data)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] ev, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd);
        @(negedge clk);
        core_valid = 1'b1; core_event = ev; core_addr = a; core_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        core_valid = 1'b0;
    endtask

    // grant, then stop at the falling edge after the replay edge
    task automatic grant(input logic [2:0] st, input logic [DW-1:0] d);
        @(negedge clk);
        grant_valid = 1'b1; grant_state = st; grant_data = d;
        @(posedge clk);
        @(negedge clk);
        grant_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill(input logic [2:0] ev, input logic [AW-1:0] a,
                        input logic [2:0] st, input logic [DW-1:0] d);
        send(ev, a, 16'h0);
        grant(st, d);
    endtask

    task automatic expect_read(input string rq, input logic [AW-1:0] a,
                               input logic [DW-1:0] d);
        send(E_LD, a, 16'h0);
        chk(rq, "read hit resp_valid", {31'd0, resp_valid}, 32'd1);
        chk(rq, "read hit data", {16'd0, resp_data}, {16'd0, d});
        chk(rq, "read hit no request", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11", "ready", {31'd0, core_ready}, 32'd1);
        chk("R11", "resp_valid", {31'd0, resp_valid}, 32'd0);
        chk("R11", "req_valid", {31'd0, req_valid}, 32'd0);
        chk("R11", "perm_hold", {31'd0, perm_hold}, 32'd0);
    endtask

    task automatic t_load_miss();
        send(E_LD, 12'h101, 16'h0);
        chk("R1", "miss req_valid", {31'd0, req_valid}, 32'd1);
        chk("R9", "miss opcode read-shared", {29'd0, req_op}, 32'd1);
        chk("R9", "miss address", {20'd0, req_addr}, 32'h101);
        chk("R1", "no resp on miss", {31'd0, resp_valid}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            chk("R8", "stalled while waiting", {31'd0, core_ready}, 32'd0);
            @(negedge clk);
        end
        chk("R9", "request one cycle", {31'd0, req_valid}, 32'd0);
        grant(S_E, 16'h1111);
        chk("R8", "replayed load resp", {31'd0, resp_valid}, 32'd1);
        chk("R8", "replayed load data", {16'd0, resp_data}, 32'h1111);
        chk("R8", "ready after grant", {31'd0, core_ready}, 32'd1);
        expect_read("R1", 12'h101, 16'h1111);
    endtask

    task automatic t_ifetch_owned();
        fill(E_IF, 12'h102, S_O, 16'h2222);
        send(E_IF, 12'h102, 16'h0);
        chk("R1", "fetch hit in O resp", {31'd0, resp_valid}, 32'd1);
        chk("R1", "fetch hit in O data", {16'd0, resp_data}, 32'h2222);
        chk("R1", "fetch hit no request", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_tag_mismatch();
        send(E_LD, 12'h201, 16'h0);
        chk("R1", "tag mismatch request", {31'd0, req_valid}, 32'd1);
        chk("R1", "tag mismatch read-shared", {29'd0, req_op}, 32'd1);
        chk("R9", "tag mismatch address", {20'd0, req_addr}, 32'h201);
        grant(S_S, 16'h3333);
        chk("R1", "tag mismatch fill data", {16'd0, resp_data}, 32'h3333);
    endtask

    task automatic t_store_hit_e();
        fill(E_LD, 12'h103, S_E, 16'h0000);
        send(E_ST, 12'h103, 16'hABCD);
        chk("R2", "store hit resp", {31'd0, resp_valid}, 32'd1);
        chk("R2", "store hit data zero", {16'd0, resp_data}, 32'd0);
        chk("R2", "store hit no request", {31'd0, req_valid}, 32'd0);
        send(E_PW, 12'h103, 16'h0);
        chk("R2", "E promoted to M: rw prefetch dropped", {31'd0, req_valid}, 32'd0);
        chk("R6", "rw prefetch in M leaves ready", {31'd0, core_ready}, 32'd1);
        expect_read("R2", 12'h103, 16'hABCD);
        send(E_RP, 12'h103, 16'h0);
        chk("R2", "evict after store is modified", {29'd0, req_op}, 32'd7);
        chk("R7", "evict request valid", {31'd0, req_valid}, 32'd1);
        chk("R7", "evict does not stall", {31'd0, core_ready}, 32'd1);
        send(E_LD, 12'h103, 16'h0);
        chk("R7", "line invalid after evict", {29'd0, req_op}, 32'd1);
        grant(S_S, 16'h0055);
        chk("R7", "refill data", {16'd0, resp_data}, 32'h0055);
    endtask

    task automatic t_store_upgrade();
        send(E_ST, 12'h201, 16'h4444);
        chk("R3", "store to S upgrade", {29'd0, req_op}, 32'd3);
        chk("R3", "upgrade stalls", {31'd0, core_ready}, 32'd0);
        grant(S_M, 16'hDEAD);
        chk("R8", "store completes after grant", {31'd0, resp_valid}, 32'd1);
        expect_read("R8", 12'h201, 16'h4444);
    endtask

    task automatic t_store_getm();
        send(E_ST, 12'h104, 16'h7777);
        chk("R3", "store absent read-for-ownership", {29'd0, req_op}, 32'd2);
        grant(S_M, 16'h0000);
        chk("R3", "store done after grant", {31'd0, resp_valid}, 32'd1);
        expect_read("R3", 12'h104, 16'h7777);
    endtask

    task automatic t_atomic_hit();
        send(E_AT, 12'h104, 16'h0011);
        chk("R4", "hold cycle 1", {31'd0, perm_hold}, 32'd1);
        chk("R4", "no resp cycle 1", {31'd0, resp_valid}, 32'd0);
        chk("R4", "no request", {31'd0, req_valid}, 32'd0);
        chk("R4", "core stalled", {31'd0, core_ready}, 32'd0);
        @(negedge clk);
        chk("R4", "hold cycle 2", {31'd0, perm_hold}, 32'd1);
        chk("R4", "no resp cycle 2", {31'd0, resp_valid}, 32'd0);
        @(negedge clk);
        chk("R4", "hold released", {31'd0, perm_hold}, 32'd0);
        chk("R4", "atomic resp", {31'd0, resp_valid}, 32'd1);
        chk("R4", "atomic old value", {16'd0, resp_data}, 32'h7777);
        expect_read("R4", 12'h104, 16'h7788);
    endtask

    task automatic t_atomic_owned();
        send(E_AT, 12'h102, 16'h0001);
        chk("R3", "atomic on O upgrade", {29'd0, req_op}, 32'd3);
        grant(S_M, 16'h9999);
        chk("R4", "hold after grant", {31'd0, perm_hold}, 32'd1);
        @(negedge clk);
        chk("R4", "hold second cycle", {31'd0, perm_hold}, 32'd1);
        @(negedge clk);
        chk("R4", "atomic resp after upgrade", {31'd0, resp_valid}, 32'd1);
        chk("R8", "upgrade kept word", {16'd0, resp_data}, 32'h2222);
        expect_read("R4", 12'h102, 16'h2223);
    endtask

    task automatic t_prefetch_ro();
        send(E_PR, 12'h201, 16'h0);
        chk("R5", "ro prefetch hit no request", {31'd0, req_valid}, 32'd0);
        chk("R5", "ro prefetch hit no resp", {31'd0, resp_valid}, 32'd0);
        chk("R5", "ro prefetch hit ready", {31'd0, core_ready}, 32'd1);
        send(E_PR, 12'h105, 16'h0);
        chk("R5", "ro prefetch miss read-shared", {29'd0, req_op}, 32'd1);
        grant(S_S, 16'h5555);
        chk("R5", "ro prefetch grant no resp", {31'd0, resp_valid}, 32'd0);
        chk("R5", "ready after prefetch grant", {31'd0, core_ready}, 32'd1);
        expect_read("R5", 12'h105, 16'h5555);
    endtask

    task automatic t_prefetch_rw();
        send(E_PW, 12'h105, 16'h0);
        chk("R6", "rw prefetch on S upgrade", {29'd0, req_op}, 32'd3);
        grant(S_M, 16'h0);
        chk("R6", "rw prefetch grant no resp", {31'd0, resp_valid}, 32'd0);
        chk("R6", "ready after rw prefetch", {31'd0, core_ready}, 32'd1);
        send(E_PW, 12'h106, 16'h0);
        chk("R6", "rw prefetch absent rfo", {29'd0, req_op}, 32'd2);
        grant(S_M, 16'h0066);
        fill(E_LD, 12'h107, S_E, 16'h0077);
        send(E_PW, 12'h107, 16'h0);
        chk("R6", "rw prefetch on E upgrade", {29'd0, req_op}, 32'd3);
        grant(S_M, 16'h0);
    endtask

    task automatic t_replace();
        fill(E_LD, 12'h100, S_S, 16'h0001);
        send(E_RP, 12'h100, 16'h0);
        chk("R7", "evict S", {29'd0, req_op}, 32'd4);
        fill(E_LD, 12'h100, S_E, 16'h0002);
        send(E_RP, 12'h100, 16'h0);
        chk("R7", "evict E", {29'd0, req_op}, 32'd5);
        fill(E_LD, 12'h100, S_O, 16'h0003);
        send(E_RP, 12'h100, 16'h0);
        chk("R7", "evict O", {29'd0, req_op}, 32'd6);
        send(E_RP, 12'h100, 16'h0);
        chk("R7", "evict I no request", {31'd0, req_valid}, 32'd0);
    endtask

    task automatic t_reserved();
        send(E_RS, 12'h201, 16'hFFFF);
        chk("R10", "reserved no request", {31'd0, req_valid}, 32'd0);
        chk("R10", "reserved no resp", {31'd0, resp_valid}, 32'd0);
        chk("R10", "reserved ready", {31'd0, core_ready}, 32'd1);
        expect_read("R10", 12'h201, 16'h4444);
    endtask

    initial begin
        rst_n = 1'b0; core_valid = 1'b0; core_event = '0; core_addr = '0;
        core_wdata = '0; grant_valid = 1'b0; grant_state = '0; grant_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_miss();
        t_ifetch_owned();
        t_tag_mismatch();
        t_store_hit_e();
        t_store_upgrade();
        t_store_getm();
        t_atomic_hit();
        t_atomic_owned();
        t_prefetch_ro();
        t_prefetch_rw();
        t_replace();
        t_reserved();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule